// File: doc/BRIEF.md
# Radix-4 Montgomery Modular Multiplier

This block multiplies two operands modulo an odd modulus in the Montgomery domain. The reduction uses only additions and shifts, with no trial division. Each clock it consumes one radix-4 digit of the multiplier, so it needs about half the cycles of a one-bit-per-clock loop. This matters because a modular exponentiation is a long chain of such products, and the per-product cycle count sets the exponentiation time.

The multiplier operand is Booth recoded into signed digits in {-2,-1,0,+1,+2}. Each digit is taken from a 3-bit window made of two fresh bits plus the top bit of the previous pair, with a zero below bit 0. The operand is zero-padded by two bits, so W/2+1 digits cover it, and the Montgomery constant is therefore R = 4^(W/2+1) = 2^(W+2).

The doubled operand, the doubled modulus and the tripled modulus are registered when a request is accepted. Each iteration then only selects and adds one multiple of each. A signed accumulator with guard bits absorbs negative digits, and a last cycle folds the value into [0, N). The width W is a parameter (even, 1024 by default). A caller pulses `start` and waits for the one-cycle `done`.

Top module: `mm4_mult`

## Requirements
- R1: For odd N, A < N and B < N, the result equals A·B·R⁻¹ mod N with R = 2^(W+2).
- R2: If `start` is high with `busy` low at clock edge k, `done` is high in the cycle after edge k+W/2+2. That is W/2+1 digit cycles plus one correction cycle.
- R3: `done` is high for exactly one cycle per accepted request.
- R4: `busy` is high from the edge that accepts `start` until the edge that raises `done`, and `busy` is low whenever `done` is high. A request may be accepted in the same cycle that `done` is high.
- R5: A `start` seen while `busy` is high is ignored. The operands and modulus captured at acceptance stay in force, and the completion timing does not change.
- R6: Every delivered result lies in [0, N).
- R7: `result` changes only on the edge that raises `done`, and it holds its value otherwise.
- R8: After reset, `busy`, `done` and `result` are all zero.
- R9: If either operand is zero, the result is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Request; sampled only while idle |
| op_a | input | W | Multiplicand, less than the modulus |
| op_b | input | W | Multiplier, Booth recoded, less than the modulus |
| modulus | input | W | Odd modulus N |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle pulse: result valid |
| result | output | W | Montgomery product in [0, N) |

## Verification
Two events can fall in the same cycle. One is the completion pulse of one product together with acceptance of the next request. The other is a new request arriving while the engine is still iterating. The bench provokes the first by driving `start` in the very cycle that `done` is seen. It then requires the second product to be correct and to finish with the normal latency. It provokes the second by raising `start` with different operands in mid-run, and it judges this by comparing the original product, the unchanged latency and the absence of any extra completion pulse.

// File: rtl/mm4_pkg.sv
// Package: shared types for the radix-4 Montgomery multiplier.
// Assumes nothing beyond IEEE 1800-2017 packed types.
package mm4_pkg;

    // Signed Booth digit: magnitude 0..2 and a negate flag.
    typedef struct packed {
        logic       neg;
        logic [1:0] mag;
    } booth_digit_t;

    // Control states of the iteration engine.
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_RUN  = 2'd1,
        ST_FIX  = 2'd2
    } mm4_state_t;

endpackage

// File: rtl/mm4_booth_rec.sv
// Booth recoder: maps a 3-bit window {b(2i+1), b(2i), b(2i-1)} to a signed
// digit in {-2..+2}. The digit value is -2*w[2] + w[1] + w[0].
// Assumes the caller supplies the overlap bit (zero for the first digit).
module mm4_booth_rec
    import mm4_pkg::*;
(
    input  logic [2:0]   win,
    output booth_digit_t dig
);

    // Decode the window into magnitude and sign.
    always_comb begin
        unique case (win)
            3'b001, 3'b010: dig = '{neg: 1'b0, mag: 2'd1};
            3'b011:         dig = '{neg: 1'b0, mag: 2'd2};
            3'b100:         dig = '{neg: 1'b1, mag: 2'd2};
            3'b101, 3'b110: dig = '{neg: 1'b1, mag: 2'd1};
            default:        dig = '{neg: 1'b0, mag: 2'd0};
        endcase
    end

endmodule

// File: rtl/mm4_mult_sel.sv
// Digit multiple selector: forms the signed term digit*A at accumulator
// width from the stored A and 2A. Assumes AW >= W+2 so that sign and
// magnitude both fit.
module mm4_mult_sel
    import mm4_pkg::*;
#(
    parameter int W  = 1024,
    parameter int AW = W + 4
) (
    input  booth_digit_t          dig,
    input  logic [W-1:0]          a_val,
    input  logic [W:0]            a_dbl,
    output logic signed [AW-1:0]  term
);

    logic signed [AW-1:0] mag_v;

    // Pick |digit|*A, then apply the digit sign.
    always_comb begin
        unique case (dig.mag)
            2'd1:    mag_v = signed'({{(AW-W){1'b0}}, a_val});
            2'd2:    mag_v = signed'({{(AW-W-1){1'b0}}, a_dbl});
            default: mag_v = '0;
        endcase
        term = dig.neg ? -mag_v : mag_v;
    end

endmodule

// File: rtl/mm4_qsel.sv
// Reduction selector: picks q in 0..3 with (low + q*N) = 0 mod 4, using
// (-N^-1) mod 4 = {~N[1], 1} for odd N, and returns q*N from the stored
// multiples. Assumes N is odd.
module mm4_qsel #(
    parameter int W = 1024
) (
    input  logic [1:0]   low2,
    input  logic [W-1:0] n_val,
    input  logic [W:0]   n_dbl,
    input  logic [W+1:0] n_tri,
    output logic [W+1:0] qn
);

    logic [1:0] nprime;
    logic [3:0] prod;
    logic [1:0] q;

    // Quotient digit from the low bits, then select the matching multiple.
    always_comb begin
        nprime = {~n_val[1], 1'b1};
        prod   = {2'b00, low2} * {2'b00, nprime};
        q      = prod[1:0];
        unique case (q)
            2'd1:    qn = {2'b00, n_val};
            2'd2:    qn = {1'b0, n_dbl};
            2'd3:    qn = n_tri;
            default: qn = '0;
        endcase
    end

endmodule

// File: rtl/mm4_mult.sv
// Radix-4 Montgomery multiplier top. It accepts A, B and an odd N on start,
// runs W/2+1 Booth-digit iterations, then folds the result into [0, N) in one
// correction cycle. Assumes W is even, A < N, B < N and N odd.
module mm4_mult
    import mm4_pkg::*;
#(
    parameter int W = 1024
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         start,
    input  logic [W-1:0] op_a,
    input  logic [W-1:0] op_b,
    input  logic [W-1:0] modulus,
    output logic         busy,
    output logic         done,
    output logic [W-1:0] result
);

    localparam int DIGITS = W / 2 + 1;
    localparam int AW     = W + 4;
    localparam int CW     = $clog2(DIGITS + 1);
    localparam int BW     = W + 2;

    mm4_state_t           state;
    logic [CW-1:0]        cnt;
    logic [W-1:0]         a_r;
    logic [W:0]           a2_r;
    logic [W-1:0]         n_r;
    logic [W:0]           n2_r;
    logic [W+1:0]         n3_r;
    logic [BW-1:0]        b_sh;
    logic                 b_prev;
    logic signed [AW-1:0] acc;

    booth_digit_t         dig;
    logic signed [AW-1:0] term;
    logic signed [AW-1:0] sum1;
    logic signed [AW-1:0] sum2;
    logic signed [AW-1:0] next_acc;
    logic [W+1:0]         qn;
    logic signed [AW-1:0] n_ext;
    logic signed [AW-1:0] fixed;

    mm4_booth_rec u_rec (
        .win (({b_sh[1:0], b_prev})),
        .dig (dig)
    );

    mm4_mult_sel #(.W(W), .AW(AW)) u_msel (
        .dig   (dig),
        .a_val (a_r),
        .a_dbl (a2_r),
        .term  (term)
    );

    mm4_qsel #(.W(W)) u_qsel (
        .low2  (sum1[1:0]),
        .n_val (n_r),
        .n_dbl (n2_r),
        .n_tri (n3_r),
        .qn    (qn)
    );

    // Iteration datapath: add digit multiple, add q*N, divide by four.
    always_comb begin
        sum1     = acc + term;
        sum2     = sum1 + signed'({{(AW-W-2){1'b0}}, qn});
        next_acc = sum2 >>> 2;
    end

    // Final correction: bring an accumulator in (-N, 2N) into [0, N).
    always_comb begin
        n_ext = signed'({{(AW-W){1'b0}}, n_r});
        if (acc < 0)
            fixed = acc + n_ext;
        else if (acc >= n_ext)
            fixed = acc - n_ext;
        else
            fixed = acc;
    end

    // Control and state registers: load, iterate, correct, report.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state  <= ST_IDLE;
            cnt    <= '0;
            a_r    <= '0;
            a2_r   <= '0;
            n_r    <= '0;
            n2_r   <= '0;
            n3_r   <= '0;
            b_sh   <= '0;
            b_prev <= 1'b0;
            acc    <= '0;
            done   <= 1'b0;
            result <= '0;
        end else begin
            done <= 1'b0;
            unique case (state)
                ST_IDLE: begin
                    if (start) begin
                        a_r    <= op_a;
                        a2_r   <= {op_a, 1'b0};
                        n_r    <= modulus;
                        n2_r   <= {modulus, 1'b0};
                        n3_r   <= {2'b00, modulus} + {1'b0, modulus, 1'b0};
                        b_sh   <= {2'b00, op_b};
                        b_prev <= 1'b0;
                        acc    <= '0;
                        cnt    <= '0;
                        state  <= ST_RUN;
                    end
                end
                ST_RUN: begin
                    acc    <= next_acc;
                    b_prev <= b_sh[1];
                    b_sh   <= b_sh >> 2;
                    cnt    <= cnt + 1'b1;
                    if (cnt == CW'(DIGITS - 1))
                        state <= ST_FIX;
                end
                ST_FIX: begin
                    result <= fixed[W-1:0];
                    done   <= 1'b1;
                    state  <= ST_IDLE;
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    // Busy covers the digit cycles and the correction cycle.
    assign busy = (state != ST_IDLE);

endmodule

// File: rtl/mm4_mult_chk.sv
// Protocol checker for mm4_mult, bound to every instance of the top.
// Assumes a synchronous active-low reset that is held for at least one edge.
module mm4_mult_chk #(
    parameter int W = 1024
) (
    input logic         clk,
    input logic         rst_n,
    input logic         start,
    input logic         busy,
    input logic         done,
    input logic [W-1:0] result,
    input logic [W-1:0] mod_held
);

    // R3: completion is a single-cycle pulse
    a_r3_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R4: never busy while reporting completion
    a_r4_done_not_busy: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);

    // R4: an accepted request makes the engine busy
    a_r4_start_sets_busy: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy) |=> busy);

    // R5: captured modulus is not disturbed while busy
    a_r5_modulus_held: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> $stable(mod_held));

    // R6: delivered result lies below the modulus
    a_r6_result_below_n: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (result < mod_held));

    // R7: result only moves together with done
    a_r7_result_stable: assert property (@(posedge clk) disable iff (!rst_n)
        !done |-> $stable(result));

endmodule

bind mm4_mult mm4_mult_chk #(.W(W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (start),
    .busy     (busy),
    .done     (done),
    .result   (result),
    .mod_held (n_r)
);

// File: tb/mm4_mult_tb.sv
// Bench for mm4_mult at W=8: sweeps over several odd moduli, directed corner
// operands, requests issued on the completion cycle and requests during busy.
module mm4_mult_tb;

    localparam int W      = 8;
    localparam int DIGITS = W / 2 + 1;
    localparam longint RVAL = longint'(1) << (W + 2);

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         start = 1'b0;
    logic [W-1:0] op_a = '0;
    logic [W-1:0] op_b = '0;
    logic [W-1:0] modulus = 8'd1;
    logic         busy;
    logic         done;
    logic [W-1:0] result;

    int total = 0;
    int bad   = 0;

    mm4_mult #(.W(W)) u_dut (
        .clk     (clk),
        .rst_n   (rst_n),
        .start   (start),
        .op_a    (op_a),
        .op_b    (op_b),
        .modulus (modulus),
        .busy    (busy),
        .done    (done),
        .result  (result)
    );

    always #2 clk = ~clk;

    task automatic check(input bit ok, input string tag, input longint act, input longint exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    function automatic longint ref_mont(input longint a, input longint b, input longint n);
        longint rinv = 0;
        for (longint r = 1; r < n; r++)
            if (((RVAL % n) * r) % n == 1) rinv = r;
        if (n == 1) return 0;
        return (((a * b) % n) * rinv) % n;
    endfunction

    // Issue one request at the current negedge; wait for done and judge it.
    task automatic run_op(input int a, input int b, input int n, input bit tail);
        int lat;
        longint exp;
        logic [W-1:0] held;
        exp = ref_mont(a, b, n);
        op_a = W'(a); op_b = W'(b); modulus = W'(n);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        check(busy == 1'b1, "R4 busy after accept", longint'(busy), 1);
        lat = 0;
        while (!done && lat < 40) begin
            @(negedge clk);
            lat++;
        end
        check(lat == DIGITS + 1, "R2 latency", lat, DIGITS + 1);
        check(result == W'(exp), (a == 0 || b == 0) ? "R9 zero operand" : "R1 product",
              longint'(result), exp);
        check(result < W'(n), "R6 range", longint'(result), n - 1);
        check(busy == 1'b0, "R4 idle at done", longint'(busy), 0);
        if (tail) begin
            held = result;
            @(negedge clk);
            check(done == 1'b0, "R3 single pulse", longint'(done), 0);
            check(result == held, "R7 result held", longint'(result), longint'(held));
        end
    endtask

    // Raise start with other operands while busy; the first request must win.
    task automatic run_interrupted(input int a, input int b, input int n);
        int lat;
        longint exp;
        exp = ref_mont(a, b, n);
        op_a = W'(a); op_b = W'(b); modulus = W'(n);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        @(negedge clk);
        op_a = W'(n - 1); op_b = W'(n - 2); modulus = W'(n + 2);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        lat = 2;
        while (!done && lat < 40) begin
            @(negedge clk);
            lat++;
        end
        check(lat == DIGITS + 1, "R5 latency unchanged", lat, DIGITS + 1);
        check(result == W'(exp), "R5 first operands kept", longint'(result), exp);
        for (int i = 0; i < 4; i++) begin
            @(negedge clk);
            check(done == 1'b0 && busy == 1'b0, "R5 no extra run",
                  longint'({busy, done}), 0);
        end
    endtask

    initial begin
        #(4 * 150000);
        bad++;
        total++;
        $display("FAIL watchdog R2 actual=timeout expected=finish");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        int mods[6] = '{3, 5, 7, 13, 101, 255};
        int corner[3];
        repeat (4) @(negedge clk);
        // R8: reset state
        check(busy == 1'b0 && done == 1'b0, "R8 reset flags", longint'({busy, done}), 0);
        check(result == '0, "R8 reset result", longint'(result), 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(busy == 1'b0 && result == '0, "R8 idle after reset", longint'(result), 0);

        foreach (mods[m]) begin
            int n = mods[m];
            int step = (n > 16) ? 7 : 1;
            for (int a = 0; a < n; a += step)
                for (int b = 0; b < n; b += step)
                    run_op(a, b, n, 1'b1);
            corner = '{0, 1, n - 1};
            for (int i = 0; i < 3; i++)
                for (int j = 0; j < 3; j++)
                    run_op(corner[i], corner[j], n, 1'b1);
        end

        // R4: new request accepted on the completion cycle, back to back
        run_op(200, 17, 251, 1'b0);
        run_op(250, 250, 251, 1'b0);
        run_op(1, 249, 251, 1'b1);

        // R5: start during busy is ignored
        run_interrupted(45, 99, 127);
        run_interrupted(126, 3, 127);

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule